// File: doc/BRIEF.md
# Set-Dueling Insertion RRPV Selector

This block supplies the re-reference prediction value (RRPV) that a cache writes into a newly filled line on every miss. It chooses between two insertion rules. The static rule always inserts with a long re-reference prediction, which resists scans. The bimodal rule inserts almost every line with a distant prediction, which resists thrashing. The choice is made per set index.

A fixed function of the set index marks a small group of sets as static-rule leaders and another group as bimodal-rule leaders. The remaining sets are followers. Misses in the leader sets move a single saturating selection counter, and follower sets adopt whichever rule that counter currently favours. The output is combinational in the presented set index and the current state, so the cache reads it in the same cycle as the miss strobe. State updates take effect at the following clock edge. Victim search and tag handling belong to the surrounding cache.

Top module: `rrpv_insert_selector`

## Requirements
- R1: A static-leader set always gets insertion value 2^M-2 (2 for M=2), whatever the selection counter holds.
- R2: A bimodal insertion gives 2^M-2 when a 5-bit count of earlier bimodal insertions is zero, and 2^M-1 otherwise. The count advances by one, wrapping at 32, only on a miss that uses the bimodal rule.
- R3: A follower set uses the bimodal rule when the most significant bit of the selection counter is 1, and the static rule otherwise.
- R4: A miss in a static-leader set increments the selection counter, and the counter holds at its all-ones maximum.
- R5: A miss in a bimodal-leader set decrements the selection counter, and the counter holds at zero.
- R6: Misses in follower sets leave the selection counter unchanged.
- R7: After reset the selection counter holds its midpoint 2^(P-1), so followers start on the bimodal rule, and the bimodal count is zero, so the first bimodal insertion gives 2^M-2.
- R8: With the index split into a top 5-bit field and a bottom 5-bit field, a set is a static leader when the two fields are equal and a bimodal leader when the top field equals the bitwise inverse of the bottom field. For a 10-bit index this gives 32 sets of each kind.
- R9: While the miss strobe is low, neither the selection counter nor the bimodal count changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | SET_BITS | Index of the set being accessed |
| miss | input | 1 | High for one cycle per miss in set_idx |
| insert_rrpv | output | RRPV_BITS | Insertion value for a fill into set_idx |

## Verification
insert_rrpv is due in the same cycle as the set index that produces it. The effect of a miss on the selection counter and on the bimodal count is visible from the next cycle onward. The bench therefore drives each access at the falling edge and samples the output 1 ns later, before the rising edge that commits the miss. It advances its arithmetic model only for that edge, so every later probe sees the state the requirements predict. Saturation at both ends is exposed by probing a follower after each leader miss, which reveals the exact step at which the counter's top bit flips.

// File: rtl/rrpv_insert_selector.sv
module rrpv_insert_selector #(
  parameter int SET_BITS   = 10,
  parameter int FIELD_BITS = 5,
  parameter int RRPV_BITS  = 2,
  parameter int PSEL_BITS  = 10,
  parameter int BIP_BITS   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SET_BITS-1:0]  set_idx,
  input  logic                 miss,
  output logic [RRPV_BITS-1:0] insert_rrpv
);

  localparam logic [RRPV_BITS-1:0] RRPV_DIST = '1;
  localparam logic [RRPV_BITS-1:0] RRPV_LONG = {{(RRPV_BITS-1){1'b1}}, 1'b0};
  localparam logic [PSEL_BITS-1:0] PSEL_MAX  = '1;
  localparam logic [PSEL_BITS-1:0] PSEL_MID  = {1'b1, {(PSEL_BITS-1){1'b0}}};

  logic [PSEL_BITS-1:0]  psel;
  logic [BIP_BITS-1:0]   bip_cnt;
  logic [FIELD_BITS-1:0] hi_field, lo_field;
  logic                  lead_static, lead_bimodal, use_bimodal;

  assign hi_field     = set_idx[SET_BITS-1 -: FIELD_BITS];
  assign lo_field     = set_idx[FIELD_BITS-1:0];
  assign lead_static  = (hi_field == lo_field);
  assign lead_bimodal = (hi_field == ~lo_field);
  assign use_bimodal  = lead_bimodal | (~lead_static & psel[PSEL_BITS-1]);
  assign insert_rrpv  = (use_bimodal && bip_cnt != '0) ? RRPV_DIST : RRPV_LONG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel <= PSEL_MID;
    end else if (miss && lead_static && psel != PSEL_MAX) begin
      psel <= psel + 1'b1;
    end else if (miss && lead_bimodal && psel != '0) begin
      psel <= psel - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bip_cnt <= '0;
    else if (miss && use_bimodal) bip_cnt <= bip_cnt + 1'b1;
  end

  assert_static_leader_long_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lead_static |-> insert_rrpv == RRPV_LONG);

  assert_bip_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && use_bimodal) |=> bip_cnt == $past(bip_cnt) + 1'b1);

  assert_bip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss && use_bimodal) |=> $stable(bip_cnt));

  assert_psel_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && lead_static && psel != PSEL_MAX) |=> psel == $past(psel) + 1'b1);

  assert_psel_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && lead_static && psel == PSEL_MAX) |=> psel == PSEL_MAX);

  assert_psel_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && lead_bimodal && psel != '0) |=> psel == $past(psel) - 1'b1);

  assert_psel_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && lead_bimodal && psel == '0) |=> psel == '0);

  assert_psel_follower_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lead_static && !lead_bimodal) |=> $stable(psel));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |=> ($stable(psel) && $stable(bip_cnt)));

endmodule

// File: tb/rrpv_insert_selector_bench.sv
module rrpv_insert_selector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] set_idx = '0;
  logic       miss = 1'b0;
  logic [1:0] insert_rrpv;

  int checks = 0;
  int fails = 0;
  int mpsel = 512;
  int mbcnt = 0;
  bit done = 0;

  localparam int SL = 99;   // top field 3, bottom field 3: static leader
  localparam int BL = 124;  // top field 3, bottom field 28: bimodal leader
  localparam int FO = 34;   // top field 1, bottom field 2: follower

  always #2 clk = ~clk;

  rrpv_insert_selector u_rrpv_insert_selector (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .miss(miss), .insert_rrpv(insert_rrpv)
  );

  function automatic int kind(input int idx);
    int hi = (idx >> 5) & 31;
    int lo = idx & 31;
    if (hi == lo) return 1;
    if (hi == (~lo & 31)) return 2;
    return 0;
  endfunction

  function automatic bit bim_now(input int idx);
    int k = kind(idx);
    return (k == 2) || (k == 0 && mpsel >= 512);
  endfunction

  function automatic int expect_rrpv(input int idx);
    return (bim_now(idx) && mbcnt != 0) ? 3 : 2;
  endfunction

  task automatic access(input int idx, input bit m, input string tag);
    int exp;
    @(negedge clk);
    set_idx = idx[9:0];
    miss = m;
    #1;
    exp = expect_rrpv(idx);
    checks++;
    if (insert_rrpv !== exp[1:0]) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, insert_rrpv, exp);
    end
    if (m) begin
      if (bim_now(idx)) mbcnt = (mbcnt + 1) % 32;
      if (kind(idx) == 1 && mpsel < 1023) mpsel++;
      else if (kind(idx) == 2 && mpsel > 0) mpsel--;
    end
    @(posedge clk);
    #1 miss = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 1024; i++) access(i, 1'b0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7: follower after reset: first bimodal fill long, second distant
    access(FO, 1'b1, "R7 first bimodal fill");
    access(FO, 1'b1, "R7 second fill shows bimodal");
    // R8 R1 R3 R9: full index sweep without misses, followers on bimodal
    sweep("R8/R1/R3/R9 sweep psel high");
    // R2: bimodal-leader run; long on every 32nd, psel falls to 442
    for (int k = 0; k < 70; k++) access(BL, 1'b1, "R2/R5 bimodal leader run");
    // R6 R3: follower misses now static, psel unchanged
    for (int k = 0; k < 20; k++) access(FO, 1'b1, "R6/R3 follower static");
    // R2: static-rule misses must not advance bimodal count
    for (int k = 0; k < 10; k++) access(SL, 1'b1, "R1/R2 static leader");
    access(BL, 1'b1, "R2 count resumes");
    sweep("R8/R1/R3/R9 sweep psel low");
    // R4: drive to maximum, then measure by decrementing with follower probes
    for (int k = 0; k < 1100; k++) access(SL, 1'b1, "R4 saturate high");
    for (int k = 0; k < 520; k++) begin
      access(BL, 1'b1, "R4/R5 step down");
      access(FO, 1'b0, "R4 follower probe");
    end
    // R5: drive to zero, then measure by incrementing
    for (int k = 0; k < 1100; k++) access(BL, 1'b1, "R5 saturate low");
    for (int k = 0; k < 520; k++) begin
      access(SL, 1'b1, "R5/R4 step up");
      access(FO, 1'b0, "R5 follower probe");
    end
    for (int k = 0; k < 40; k++) access(FO, 1'b1, "R2/R3 follower bimodal fills");
    sweep("R8/R1/R3/R9 final sweep");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule